// File: doc/BRIEF.md
# Interleaving 80-to-64 Transmit Gearbox

This block sits on the transmit side between a wide, slow lane datapath and a narrower, faster transceiver interface. For every lane it takes a 64-bit main group and a 16-bit alternate group and weaves them into one 80-bit word. In that word, each 8-bit slice of the main group is followed by a 2-bit slice of the alternate group. The 80-bit stream is then repacked into 64-bit words at a 5:4 rate ratio, least significant bit first. No bit is lost or repeated across word boundaries.

The design runs on a single fast clock. An internal modulo-5 sequencer raises an accept strobe in four cycles out of every five, and this strobe stands in for the slower input clock. Upstream logic must present a fresh lane word in every cycle where the accept strobe is high. In steady state the block emits one 64-bit word per lane in every cycle. The lane count is a parameter, and all lanes share one sequencer.

Top module: `ilv_gearbox`

## Requirements
- R1: Within each lane's 80-bit word, bits [10g+7:10g] carry main bits [8g+7:8g] and bits [10g+9:10g+8] carry alternate bits [2g+1:2g], for g = 0..7.
- R2: The outputs of a lane, concatenated least significant bit first, equal that lane's accepted 80-bit words concatenated least significant bit first, with no gap, drop or duplicate.
- R3: Counting cycles from 0 after reset is released, `inAccept` is low exactly in the cycles whose count modulo 5 equals 4, and high in all others.
- R4: `outValid` is low in the first cycle after reset release, goes high in the next cycle (after the first accepted word) and then stays high every cycle.
- R5: While reset is applied, `outValid` and `outData` read zero one clock after the first reset edge.
- R6: Each lane's output depends only on that lane's own main and alternate inputs. Lane l occupies bits [64l+63:64l] of `outData`, [64l+63:64l] of `mainData` and [16l+15:16l] of `altData`.
- R7: Values on `mainData` and `altData` in a cycle where `inAccept` is low have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock (output rate) |
| rst | input | 1 | Synchronous active-high reset |
| mainData | input | LANES*MAIN_W (256) | Main groups, lane l at [64l+63:64l] |
| altData | input | LANES*ALT_W (64) | Alternate groups, lane l at [16l+15:16l] |
| inAccept | output | 1 | High when the current input words are taken at the next edge |
| outData | output | LANES*OUT_W (256) | Repacked words, lane l at [64l+63:64l] |
| outValid | output | 1 | High when outData holds a new word |

## Verification
The embedded assertions check a set of properties on every cycle. A cycle with the accept strobe low is always followed by a cycle with it high. The residue fill never exceeds one output word. No residue bit above the fill level is ever set. Once valid output starts, it never drops without a reset, and reset clears it. The interleave bit mapping, the bit-exact continuity of the stream across all five phase alignments, the independence of lanes and the fact that inputs offered while the strobe is low are ignored can only be shown by the bench's scenarios. In those scenarios a scoreboard pushes the bit-level image of each accepted word and compares it against every output word, using random, lane-distinct constant and walking-bit data, with a reset applied in the middle of the stream.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  // Strobes from the shared sequencer to every lane datapath
  typedef struct packed {
    logic accept;  // lane word is merged into the residue at this edge
    logic emit;    // the low OUT_W residue bits leave as an output word
  } ilvStrobes_t;

endpackage

// File: rtl/ilv_interleave.sv
module ilv_interleave #(
  parameter int MAIN_W     = 64,
  parameter int ALT_W      = 16,
  parameter int MAIN_CHUNK = 8,
  parameter int ALT_CHUNK  = 2
) (
  input  logic [MAIN_W-1:0]       mainIn,
  input  logic [ALT_W-1:0]        altIn,
  output logic [MAIN_W+ALT_W-1:0] wordOut
);

  localparam int GROUPS = MAIN_W / MAIN_CHUNK;
  localparam int STRIDE = MAIN_CHUNK + ALT_CHUNK;

  // Each stride: a main slice in the low bits, then an alternate slice (R1)
  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    assign wordOut[g*STRIDE +: MAIN_CHUNK] = mainIn[g*MAIN_CHUNK +: MAIN_CHUNK];
    assign wordOut[g*STRIDE+MAIN_CHUNK +: ALT_CHUNK] = altIn[g*ALT_CHUNK +: ALT_CHUNK];
  end

endmodule

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
  import ilv_pkg::*;
#(
  parameter int IN_W   = 80,
  parameter int OUT_W  = 64,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output ilvStrobes_t       strobes,
  output logic [FILL_W-1:0] fill,
  output logic              outValid
);

  // Input words per period = PERIOD-1, output words per period = PERIOD
  localparam int PERIOD = IN_W / (IN_W - OUT_W);
  localparam int PH_W   = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [PH_W-1:0]   phase;
  logic [FILL_W-1:0] total;
  logic [FILL_W-1:0] fillNext;

  always_comb begin
    strobes.accept = (phase != PH_W'(PERIOD - 1));
    total          = fill + (strobes.accept ? FILL_W'(IN_W) : '0);
    strobes.emit   = (total >= FILL_W'(OUT_W));
    fillNext       = strobes.emit ? (total - FILL_W'(OUT_W)) : total;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      fill     <= '0;
      outValid <= 1'b0;
    end else begin
      phase    <= (phase == PH_W'(PERIOD - 1)) ? '0 : phase + 1'b1;
      fill     <= fillNext;
      outValid <= strobes.emit;
    end
  end

  // R3
  accept_gap_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.accept |=> strobes.accept);

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill <= FILL_W'(OUT_W));

  // R4
  valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |=> outValid);

  // R5
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);

endmodule

// File: rtl/ilv_lane.sv
module ilv_lane
  import ilv_pkg::*;
#(
  parameter int IN_W   = 80,
  parameter int OUT_W  = 64,
  parameter int FILL_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ilvStrobes_t       strobes,
  input  logic [FILL_W-1:0] fill,
  input  logic [IN_W-1:0]   inWord,
  output logic [OUT_W-1:0]  outWord
);

  localparam int RES_W = IN_W + OUT_W;

  logic [RES_W-1:0] residue;
  logic [RES_W-1:0] merged;

  // New word lands directly above the bits still waiting to leave
  always_comb begin
    merged = residue;
    if (strobes.accept) merged = merged | (RES_W'(inWord) << fill);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      residue <= '0;
      outWord <= '0;
    end else if (strobes.emit) begin
      outWord <= merged[OUT_W-1:0];
      residue <= merged >> OUT_W;
    end else begin
      residue <= merged;
    end
  end

  // R2
  residue_clean_chk: assert property (@(posedge clk) disable iff (rst)
    (residue >> fill) == '0);

endmodule

// File: rtl/ilv_gearbox.sv
module ilv_gearbox
  import ilv_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int MAIN_W     = 64,
  parameter int ALT_W      = 16,
  parameter int MAIN_CHUNK = 8,
  parameter int ALT_CHUNK  = 2,
  parameter int OUT_W      = 64
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES*MAIN_W-1:0] mainData,
  input  logic [LANES*ALT_W-1:0]  altData,
  output logic                    inAccept,
  output logic [LANES*OUT_W-1:0]  outData,
  output logic                    outValid
);

  localparam int IN_W   = MAIN_W + ALT_W;
  localparam int FILL_W = $clog2(IN_W + OUT_W + 1);

  ilvStrobes_t       strobes;
  logic [FILL_W-1:0] fill;

  ilv_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .FILL_W(FILL_W)) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .fill     (fill),
    .outValid (outValid)
  );

  assign inAccept = strobes.accept;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [IN_W-1:0] laneWord;

    ilv_interleave #(
      .MAIN_W(MAIN_W), .ALT_W(ALT_W),
      .MAIN_CHUNK(MAIN_CHUNK), .ALT_CHUNK(ALT_CHUNK)
    ) ilv_i (
      .mainIn  (mainData[l*MAIN_W +: MAIN_W]),
      .altIn   (altData[l*ALT_W +: ALT_W]),
      .wordOut (laneWord)
    );

    ilv_lane #(.IN_W(IN_W), .OUT_W(OUT_W), .FILL_W(FILL_W)) lane_i (
      .clk     (clk),
      .rst     (rst),
      .strobes (strobes),
      .fill    (fill),
      .inWord  (laneWord),
      .outWord (outData[l*OUT_W +: OUT_W])
    );
  end

endmodule

// File: tb/ilv_gearbox_tb_top.sv
module ilv_gearbox_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int MAIN_W = 64;
  localparam int ALT_W  = 16;
  localparam int OUT_W  = 64;
  localparam int IN_W   = MAIN_W + ALT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [LANES*MAIN_W-1:0] mainData = '0;
  logic [LANES*ALT_W-1:0]  altData  = '0;
  logic                    inAccept;
  logic [LANES*OUT_W-1:0]  outData;
  logic                    outValid;

  ilv_gearbox dut_i (
    .clk(clk), .rst(rst), .mainData(mainData), .altData(altData),
    .inAccept(inAccept), .outData(outData), .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int pattern = 0;
  int sinceRel = 0;
  int wordCnt = 0;
  bit rstSeen = 1'b0;
  bit done = 1'b0;

  // Scoreboard: one entry per stream bit position, one bit per lane
  logic [LANES-1:0] bitQ[$];

  always @(posedge clk) rstSeen <= rst;

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Bench's own statement of the R1 mapping
  function automatic logic [IN_W-1:0] weave(input logic [MAIN_W-1:0] m,
                                            input logic [ALT_W-1:0] a);
    logic [IN_W-1:0] w;
    for (int k = 0; k < IN_W; k++) begin
      if (k % 10 < 8) w[k] = m[(k/10)*8 + k%10];
      else            w[k] = a[(k/10)*2 + k%10 - 8];
    end
    return w;
  endfunction

  task automatic driveWord(input bit push);
    logic [MAIN_W-1:0] m;
    logic [ALT_W-1:0]  a;
    logic [IN_W-1:0]   w[LANES];
    for (int l = 0; l < LANES; l++) begin
      case (pattern)
        1: begin
          m = (l % 2 == 0) ? '0 : '1;
          a = (l % 2 == 0) ? '1 : '0;
        end
        2: begin
          m = 64'h1 << ((wordCnt + 3*l) % MAIN_W);
          a = 16'h1 << ((wordCnt + l) % ALT_W);
        end
        default: begin
          m = {$urandom, $urandom};
          a = 16'($urandom);
        end
      endcase
      if (!push) begin
        m = {$urandom, $urandom};
        a = 16'($urandom);
      end
      mainData[l*MAIN_W +: MAIN_W] = m;
      altData[l*ALT_W +: ALT_W]    = a;
      w[l] = weave(m, a);
    end
    if (push) begin
      for (int k = 0; k < IN_W; k++) begin
        logic [LANES-1:0] e;
        for (int l = 0; l < LANES; l++) e[l] = w[l][k];
        bitQ.push_back(e);
      end
      wordCnt++;
    end
  endtask

  // Monitor first (result of earlier words), then driver for the next edge
  always @(negedge clk) begin
    if (!done) begin
      if (rst) begin
        if (rstSeen) begin
          // R5
          chk(!outValid && outData == '0, "R5 reset clears outputs",
              {outValid, outData}, '0);
        end
        bitQ.delete();
        sinceRel = 0;
      end else begin
        // R4
        chk(outValid == (sinceRel > 0), "R4 valid timing", outValid, (sinceRel > 0));
        // R3
        chk(inAccept == (sinceRel % 5 != 4), "R3 accept cadence", inAccept,
            (sinceRel % 5 != 4));
        if (outValid) begin
          if (bitQ.size() < OUT_W) begin
            chk(1'b0, "R2 stream underflow", bitQ.size(), OUT_W);
          end else begin
            logic [OUT_W-1:0] exp[LANES];
            for (int i = 0; i < OUT_W; i++) begin
              logic [LANES-1:0] e;
              e = bitQ.pop_front();
              for (int l = 0; l < LANES; l++) exp[l][i] = e[l];
            end
            for (int l = 0; l < LANES; l++)
              // R1 R2 R6 R7: mapping, continuity, lane isolation, ignored idle data
              chk(outData[l*OUT_W +: OUT_W] == exp[l], "R1/R2/R6/R7 lane word",
                  outData[l*OUT_W +: OUT_W], exp[l]);
          end
        end
        driveWord(inAccept);
        sinceRel++;
      end
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    pattern = 0;
    repeat (200) @(posedge clk);
    pattern = 1;
    repeat (60) @(posedge clk);
    pattern = 2;
    repeat (200) @(posedge clk);
    #1 rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    pattern = 0;
    repeat (300) @(posedge clk);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule